// File: doc/BRIEF.md
# Bus Lock and Hold Arbiter

This block drives the active-low bus lock output of a processor bus interface and decides when another local bus master may take the bus. A lock prefix strobe from the instruction decoder asserts the lock on the next clock. The lock stays asserted until the bus cycle generator reports the end of the final bus cycle of the instruction that follows the prefix. While the lock is held, no other master can insert memory cycles between the locked accesses of a read-modify-write sequence.

A hold request from another master is an asynchronous level. It passes through a synchronizer before the arbiter uses it. A request that arrives during a lock is stored as pending. It is granted on the same clock edge that drops the lock. Outside a lock, a grant is issued only at a bus cycle boundary or while the bus is idle. While the grant is active, a float enable three-states the address, data and control drivers. A lock prefix that arrives during a grant is stored and takes effect once the bus is regained.

Top module: `bus_lock_arb`

## Requirements
- R1: After reset, `lock_no` is 1, and `hold_gnt_o` and `float_en_o` are both 0.
- R2: When `lock_prefix_i` is 1 at a rising edge and no grant is active or being issued, `lock_no` is 0 after that edge.
- R3: While the lock is held, `lock_no` goes back to 1 only after an edge at which `cyc_end_i` and `last_cyc_i` are both 1. An edge with only one of the two at 1 leaves the lock asserted.
- R4: `hold_req_i` passes through a two-flop synchronizer. With the bus idle, a request first sampled at edge k produces `hold_gnt_o` = 1 after edge k+2, and not earlier.
- R5: `hold_gnt_o` is never 1 while `lock_no` is 0. A request that is present during a lock is granted at the edge that releases the lock, so `lock_no` rises and `hold_gnt_o` rises together.
- R6: A request that reached the synchronizer output during a lock stays recorded even if it is withdrawn before the lock ends. At release it receives a grant that lasts one clock.
- R7: Outside a lock, a grant is issued only at an edge where `cyc_end_i` or `bus_idle_i` is 1. A request made during a busy bus cycle with no cycle end gets no grant.
- R8: The grant is removed one clock after the synchronized request falls. For a request removed before edge m, `hold_gnt_o` is still 1 after edges m and m+1 and is 0 after edge m+2.
- R9: `float_en_o` is 1 exactly when `hold_gnt_o` is 1.
- R10: A lock prefix seen while a grant is active does not assert the lock at that point. The prefix is stored, and `lock_no` goes to 0 one clock after the grant is removed. The stored prefix is served before any new grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lock_prefix_i | input | 1 | One-cycle strobe: lock prefix decoded |
| cyc_end_i | input | 1 | Strobe: the current bus cycle ends at this edge |
| last_cyc_i | input | 1 | Qualifies `cyc_end_i`: the ending cycle is the last one of the instruction |
| bus_idle_i | input | 1 | Level: no bus cycle in progress |
| hold_req_i | input | 1 | Asynchronous hold request level from another master |
| lock_no | output | 1 | Bus lock, active low |
| hold_gnt_o | output | 1 | Hold grant to the requesting master |
| float_en_o | output | 1 | Three-state enable for the address, data and control drivers |

## Verification
The arbiter is exercised with several request patterns, each separating one behaviour from the others:
- **Request on an idle bus.** This measures the synchronizer latency.
- **Request on a busy bus, then a lone cycle-end strobe.** This shows that grants wait for a cycle boundary.
- **Request inside a lock.** The grant must coincide with the release edge.
- **Short request inside a lock.** The request is withdrawn before the release, which separates a recorded request from a live one.

Lock release is driven with a cycle-end strobe alone, a last-cycle flag alone, and both together, so an early release is caught. The defer case sends a prefix during a grant and checks that the lock follows the grant's removal by exactly one clock.

// File: rtl/bus_lock_arb_pkg.sv
package bus_lock_arb_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/bla_sync.sv
module bla_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sq;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sq <= '0;
        else         sq <= {sq[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sq[STAGES-1];
endmodule

// File: rtl/bla_lock_ctrl.sv
module bla_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_prefix_i,
  input  logic cyc_end_i,
  input  logic last_cyc_i,
  input  logic gnt_i,
  input  logic gnt_set_i,
  output logic lock_o,
  output logic lock_pend_o,
  output logic release_o
);
  logic lock_q, lock_pend_q;
  logic want, lock_start;

  assign release_o  = lock_q & cyc_end_i & last_cyc_i;
  assign want       = lock_prefix_i | lock_pend_q;
  // bus owned by another master: keep the prefix until it is returned
  assign lock_start = want & ~gnt_i & ~gnt_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q      <= 1'b0;
      lock_pend_q <= 1'b0;
    end else begin
      if (lock_start)     lock_q <= 1'b1;
      else if (release_o) lock_q <= 1'b0;
      lock_pend_q <= want & ~lock_start;
    end
  end

  assign lock_o      = lock_q;
  assign lock_pend_o = lock_pend_q;

  a_r2_lock_follows_prefix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_prefix_i && !gnt_i && !gnt_set_i |=> lock_q);
  a_r3_lock_held_to_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q && !(cyc_end_i && last_cyc_i) |=> lock_q);
  a_r10_prefix_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_pend_q && gnt_i |=> lock_pend_q);
endmodule

// File: rtl/bla_hold_ctrl.sv
module bla_hold_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic lock_i,
  input  logic lock_pend_i,
  input  logic release_i,
  input  logic cyc_end_i,
  input  logic bus_idle_i,
  output logic gnt_o,
  output logic gnt_set_o,
  output logic float_en_o
);
  logic gnt_q, float_q, pend_q;
  logic boundary, gnt_set, gnt_clr;

  // outside a lock, only at a cycle boundary, and after any deferred prefix
  assign boundary = ~lock_i & ~lock_pend_i & (cyc_end_i | bus_idle_i);
  assign gnt_set  = ~gnt_q & ((release_i & (pend_q | req_i)) | (boundary & req_i));
  assign gnt_clr  = gnt_q & ~req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q   <= 1'b0;
      float_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (gnt_set)      gnt_q <= 1'b1;
      else if (gnt_clr) gnt_q <= 1'b0;
      if (gnt_set)      float_q <= 1'b1;
      else if (gnt_clr) float_q <= 1'b0;
      if (gnt_set)                pend_q <= 1'b0;
      else if (lock_i && req_i)   pend_q <= 1'b1;
    end
  end

  assign gnt_o      = gnt_q;
  assign gnt_set_o  = gnt_set;
  assign float_en_o = float_q;

  a_r7_grant_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_q && !(cyc_end_i || bus_idle_i || release_i) |=> !gnt_q);
  a_r5_no_grant_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i && !release_i |=> !gnt_q);
  a_r6_request_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && lock_i && !release_i |=> pend_q);
  a_r8_grant_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q && !req_i |=> !gnt_q);
  a_r9_float_tracks_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_q == gnt_q);
endmodule

// File: rtl/bus_lock_arb.sv
module bus_lock_arb
  import bus_lock_arb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_prefix_i,
  input  logic cyc_end_i,
  input  logic last_cyc_i,
  input  logic bus_idle_i,
  input  logic hold_req_i,
  output logic lock_no,
  output logic hold_gnt_o,
  output logic float_en_o
);
  logic req_s, lock_q, lock_pend, release_now, gnt, gnt_set;

  bla_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (hold_req_i),
    .q_o   (req_s)
  );

  bla_lock_ctrl u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lock_prefix_i(lock_prefix_i),
    .cyc_end_i    (cyc_end_i),
    .last_cyc_i   (last_cyc_i),
    .gnt_i        (gnt),
    .gnt_set_i    (gnt_set),
    .lock_o       (lock_q),
    .lock_pend_o  (lock_pend),
    .release_o    (release_now)
  );

  bla_hold_ctrl u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_s),
    .lock_i     (lock_q),
    .lock_pend_i(lock_pend),
    .release_i  (release_now),
    .cyc_end_i  (cyc_end_i),
    .bus_idle_i (bus_idle_i),
    .gnt_o      (gnt),
    .gnt_set_o  (gnt_set),
    .float_en_o (float_en_o)
  );

  assign lock_no    = ~lock_q;
  assign hold_gnt_o = gnt;

  a_r5_lock_grant_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!lock_no && hold_gnt_o));
endmodule

// File: tb/sim_bus_lock_arb.sv
`timescale 1ns/1ps
module sim_bus_lock_arb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prefix = 1'b0, cyc_end = 1'b0, last_cyc = 1'b0, idle = 1'b1, req = 1'b0;
  logic lock_n, gnt, flt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_lock_arb u0 (
    .clk_i(clk), .rst_ni(rst_n), .lock_prefix_i(prefix), .cyc_end_i(cyc_end),
    .last_cyc_i(last_cyc), .bus_idle_i(idle), .hold_req_i(req),
    .lock_no(lock_n), .hold_gnt_o(gnt), .float_en_o(flt)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", rq, act, exp);
    end
  endtask

  task automatic release_lock();
    cyc_end = 1'b1; last_cyc = 1'b1;
    step(1);
    cyc_end = 1'b0; last_cyc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 lock_no", lock_n, 1'b1);
    chk("R1 grant", gnt, 1'b0);
    chk("R1 float", flt, 1'b0);
  endtask

  task automatic t_lock_basic();
    prefix = 1'b1; step(1); prefix = 1'b0;
    chk("R2 lock after prefix", lock_n, 1'b0);
    cyc_end = 1'b1; step(1); cyc_end = 1'b0;
    chk("R3 cyc_end alone keeps lock", lock_n, 1'b0);
    last_cyc = 1'b1; step(1); last_cyc = 1'b0;
    chk("R3 last alone keeps lock", lock_n, 1'b0);
    release_lock();
    chk("R3 released at last cycle end", lock_n, 1'b1);
  endtask

  task automatic t_hold_idle();
    idle = 1'b1; req = 1'b1;
    step(1); chk("R4 no grant after 1", gnt, 1'b0);
    step(1); chk("R4 no grant after 2", gnt, 1'b0);
    step(1); chk("R4 grant after 3", gnt, 1'b1);
    chk("R9 float with grant", flt, 1'b1);
    req = 1'b0;
    step(1); chk("R8 grant kept 1", gnt, 1'b1);
    step(1); chk("R8 grant kept 2", gnt, 1'b1);
    step(1); chk("R8 grant removed", gnt, 1'b0);
    chk("R9 float off", flt, 1'b0);
  endtask

  task automatic t_busy();
    idle = 1'b0; req = 1'b1;
    step(5); chk("R7 no grant mid cycle", gnt, 1'b0);
    cyc_end = 1'b1; step(1); cyc_end = 1'b0;
    chk("R7 grant at cycle end", gnt, 1'b1);
    req = 1'b0; step(3);
    chk("R8 busy grant removed", gnt, 1'b0);
    idle = 1'b1;
  endtask

  task automatic t_lock_pending();
    prefix = 1'b1; step(1); prefix = 1'b0;
    req = 1'b1; step(4);
    chk("R5 no grant in lock", gnt, 1'b0);
    chk("R5 lock held", lock_n, 1'b0);
    release_lock();
    chk("R5 lock off at release", lock_n, 1'b1);
    chk("R5 grant at release", gnt, 1'b1);
    req = 1'b0; step(3);
    chk("R8 pending grant removed", gnt, 1'b0);
  endtask

  task automatic t_recorded();
    prefix = 1'b1; step(1); prefix = 1'b0;
    req = 1'b1; step(3);
    req = 1'b0; step(3);
    chk("R6 no grant before release", gnt, 1'b0);
    release_lock();
    chk("R6 recorded grant", gnt, 1'b1);
    chk("R6 lock off", lock_n, 1'b1);
    step(1);
    chk("R6 one-cycle grant", gnt, 1'b0);
  endtask

  task automatic t_defer();
    idle = 1'b1; req = 1'b1; step(3);
    chk("R10 grant held", gnt, 1'b1);
    prefix = 1'b1; step(1); prefix = 1'b0;
    chk("R10 no lock under grant", lock_n, 1'b1);
    req = 1'b0; step(3);
    chk("R10 grant removed", gnt, 1'b0);
    chk("R10 lock still off", lock_n, 1'b1);
    step(1);
    chk("R10 deferred lock on", lock_n, 1'b0);
    release_lock();
    chk("R10 deferred lock released", lock_n, 1'b1);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_lock_basic();
    t_hold_idle();
    t_busy();
    t_lock_pending();
    t_recorded();
    t_defer();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule